// File: doc/BRIEF.md
# Register Rename Map with Free Pool

This block translates architectural register numbers into physical register numbers for an out-of-order core whose physical register file is larger than the architectural one. Each instruction that enters the rename stage gets its two source operands translated through a mapping table. If the instruction writes a register, a fresh physical register is drawn from a pool of unused tags. That tag becomes the new mapping of the destination. The mapping it replaces is reported alongside, so the pipeline can carry it to retirement and hand it back there.

Physical registers are reclaimed only through the retire port. A tag that has merely been displaced from the table stays reserved, because older in-flight instructions may still read it. One checkpoint of the table can be taken along with a renamed instruction, for example a branch. A recover pulse then restores the checkpointed table in a single cycle. In the same cycle every tag allocated since the checkpoint goes back to the pool, while tags retired in the meantime stay free. When the pool is empty, rename stalls through its ready signal.

Top module: `reg_rename`

## Requirements
- R1: After reset, architectural register i maps to physical register i for i = 0..7, physical registers 8..15 form the free pool, and `ren_ready` is high.
- R2: Source outputs are combinational lookups of the table as it stands before the current instruction's own destination update, so a source equal to the destination returns the old mapping.
- R3: A renamed instruction with `ren_has_dst` = 1 receives the lowest-numbered free physical register on `out_dst_phys`. That tag leaves the pool and becomes the destination's mapping for every later lookup.
- R4: `out_old_phys` gives the mapping the destination held before this instruction, and it always differs from the newly allocated tag.
- R5: A renamed instruction with `ren_has_dst` = 0 neither changes the table nor consumes a pool entry.
- R6: While the pool is empty, `ren_ready` is low and no rename takes place. It rises again once a tag has been returned.
- R7: A tag on `ret_phys` with `ret_valid` = 1 rejoins the pool on the next cycle. A tag displaced from the table is never reallocated before it is retired.
- R8: A rename with `ren_ckpt` = 1 records the table as it stands after that instruction. A cycle with `recover` = 1 restores that table. In the same cycle it returns every tag allocated after the checkpoint to the pool and keeps tags retired since then free.
- R9: While `recover` is high, `ren_ready` is low.
- R10: No physical register that is currently the mapping of some architectural register is in the free pool.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ren_valid | input | 1 | Rename request present |
| ren_ready | output | 1 | Rename can accept this cycle |
| ren_has_dst | input | 1 | Instruction writes a register |
| ren_dst | input | 3 | Destination architectural register |
| ren_src1 | input | 3 | First source architectural register |
| ren_src2 | input | 3 | Second source architectural register |
| ren_ckpt | input | 1 | Take a checkpoint with this instruction |
| out_src1_phys | output | 4 | Physical mapping of first source |
| out_src2_phys | output | 4 | Physical mapping of second source |
| out_dst_phys | output | 4 | Newly allocated physical destination |
| out_old_phys | output | 4 | Previous mapping of the destination |
| ret_valid | input | 1 | Retirement frees a tag |
| ret_phys | input | 4 | Tag to return to the pool |
| recover | input | 1 | Restore checkpointed mapping |

## Verification
On every cycle, the assertions check the bookkeeping invariants of the pool. An allocated tag must have been free and leaves the pool. A retired tag rejoins it. The new tag never equals the displaced one. Ready is held low when the pool is empty or a recovery is in progress. No mapped tag is ever free. Whether the values are right can only be shown by the bench's scenarios, against a reference model of table and pool. This covers the lowest-first allocation order, the pre-update source lookup, the stall and resume around an exhausted pool, and the exact mapping and pool contents after a recovery with an intervening retirement.

// File: rtl/rn_pkg.sv
package rn_pkg;
    parameter int ARCH_REGS = 8;
    parameter int PHYS_REGS = 16;
    localparam int AW = $clog2(ARCH_REGS);
    localparam int PW = $clog2(PHYS_REGS);

    typedef logic [AW-1:0]        arch_t;
    typedef logic [PW-1:0]        phys_t;
    typedef logic [PHYS_REGS-1:0] pmask_t;
    typedef logic [ARCH_REGS-1:0][PW-1:0] map_t;

    typedef struct packed {
        logic  has_dst;
        arch_t dst;
        arch_t src1;
        arch_t src2;
    } ren_req_t;

    typedef struct packed {
        phys_t src1;
        phys_t src2;
        phys_t dst;
        phys_t old;
    } ren_rsp_t;

    // lowest set bit index; zero when mask is empty
    function automatic phys_t lowest_set(input pmask_t m);
        phys_t r;
        r = '0;
        for (int i = PHYS_REGS - 1; i >= 0; i--) begin
            if (m[i]) r = phys_t'(i);
        end
        return r;
    endfunction

    function automatic pmask_t tag_bit(input phys_t p);
        pmask_t r;
        r = '0;
        r[p] = 1'b1;
        return r;
    endfunction

    function automatic pmask_t reset_pool();
        pmask_t r;
        for (int i = 0; i < PHYS_REGS; i++) r[i] = (i >= ARCH_REGS);
        return r;
    endfunction
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table
    import rn_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  arch_t rd_a1,
    input  arch_t rd_a2,
    input  arch_t rd_ad,
    output phys_t rd_p1,
    output phys_t rd_p2,
    output phys_t rd_pold,
    input  logic  wr_en,
    input  arch_t wr_arch,
    input  phys_t wr_phys,
    input  logic  ckpt_save,
    input  logic  recover,
    output map_t  map_o
);
    map_t map_q;
    map_t ckpt_q;
    map_t map_next;
    map_t map_init;

    always_comb begin
        for (int i = 0; i < ARCH_REGS; i++) map_init[i] = phys_t'(i);
    end

    assign rd_p1   = map_q[rd_a1];
    assign rd_p2   = map_q[rd_a2];
    assign rd_pold = map_q[rd_ad];
    assign map_o   = map_q;

    always_comb begin
        map_next = map_q;
        if (wr_en) map_next[wr_arch] = wr_phys;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            map_q  <= map_init;
            ckpt_q <= map_init;
        end else if (recover) begin
            map_q  <= ckpt_q;
        end else begin
            map_q  <= map_next;
            if (ckpt_save) ckpt_q <= map_next;
        end
    end
endmodule

// File: rtl/rn_free_pool.sv
module rn_free_pool
    import rn_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   alloc_en,
    output phys_t  alloc_phys,
    output logic   any_free,
    input  logic   ret_en,
    input  phys_t  ret_phys,
    input  logic   ckpt_save,
    input  logic   recover,
    output pmask_t free_o
);
    pmask_t free_q;
    pmask_t since_q;
    pmask_t alloc_mask;
    pmask_t ret_mask;

    assign alloc_phys = lowest_set(free_q);
    assign any_free   = |free_q;
    assign alloc_mask = alloc_en ? tag_bit(alloc_phys) : '0;
    assign ret_mask   = ret_en ? tag_bit(ret_phys) : '0;
    assign free_o     = free_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            free_q  <= reset_pool();
            since_q <= '0;
        end else if (recover) begin
            free_q  <= free_q | since_q | ret_mask;
            since_q <= '0;
        end else begin
            free_q  <= (free_q & ~alloc_mask) | ret_mask;
            since_q <= ckpt_save ? '0 : (since_q | alloc_mask);
        end
    end
endmodule

// File: rtl/reg_rename.sv
module reg_rename
    import rn_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          ren_valid,
    output logic          ren_ready,
    input  logic          ren_has_dst,
    input  logic [AW-1:0] ren_dst,
    input  logic [AW-1:0] ren_src1,
    input  logic [AW-1:0] ren_src2,
    input  logic          ren_ckpt,
    output logic [PW-1:0] out_src1_phys,
    output logic [PW-1:0] out_src2_phys,
    output logic [PW-1:0] out_dst_phys,
    output logic [PW-1:0] out_old_phys,
    input  logic          ret_valid,
    input  logic [PW-1:0] ret_phys,
    input  logic          recover
);
    ren_req_t req;
    ren_rsp_t rsp;
    logic     any_free;
    logic     fire;
    logic     alloc_en;
    pmask_t   free_mask;
    map_t     map_flat;

    assign req = '{has_dst: ren_has_dst, dst: ren_dst, src1: ren_src1, src2: ren_src2};

    assign ren_ready = !recover && any_free;
    assign fire      = ren_valid && ren_ready;
    assign alloc_en  = fire && req.has_dst;

    rn_map_table u_map (
        .clk       (clk),
        .rst       (rst),
        .rd_a1     (req.src1),
        .rd_a2     (req.src2),
        .rd_ad     (req.dst),
        .rd_p1     (rsp.src1),
        .rd_p2     (rsp.src2),
        .rd_pold   (rsp.old),
        .wr_en     (alloc_en),
        .wr_arch   (req.dst),
        .wr_phys   (rsp.dst),
        .ckpt_save (fire && ren_ckpt),
        .recover   (recover),
        .map_o     (map_flat)
    );

    rn_free_pool u_pool (
        .clk        (clk),
        .rst        (rst),
        .alloc_en   (alloc_en),
        .alloc_phys (rsp.dst),
        .any_free   (any_free),
        .ret_en     (ret_valid),
        .ret_phys   (ret_phys),
        .ckpt_save  (fire && ren_ckpt),
        .recover    (recover),
        .free_o     (free_mask)
    );

    assign out_src1_phys = rsp.src1;
    assign out_src2_phys = rsp.src2;
    assign out_dst_phys  = rsp.dst;
    assign out_old_phys  = rsp.old;
endmodule

// File: rtl/reg_rename_chk.sv
module reg_rename_chk
    import rn_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   ren_valid,
    input logic   ren_ready,
    input logic   ren_has_dst,
    input phys_t  out_dst_phys,
    input phys_t  out_old_phys,
    input logic   ret_valid,
    input phys_t  ret_phys,
    input logic   recover,
    input pmask_t free_mask,
    input map_t   map_flat
);
    logic alloc;
    assign alloc = ren_valid && ren_ready && ren_has_dst;

    AST_ALLOC_WAS_FREE: assert property (@(posedge clk) disable iff (rst)
        alloc |-> free_mask[out_dst_phys]);  // R3
    AST_ALLOC_LEAVES_POOL: assert property (@(posedge clk) disable iff (rst)
        alloc && !recover |=> !free_mask[$past(out_dst_phys)]);  // R3
    AST_FRESH_DIFFERS: assert property (@(posedge clk) disable iff (rst)
        alloc |-> out_dst_phys != out_old_phys);  // R4
    AST_STALL_EMPTY: assert property (@(posedge clk) disable iff (rst)
        free_mask == '0 |-> !ren_ready);  // R6
    AST_RETIRE_FREES: assert property (@(posedge clk) disable iff (rst)
        ret_valid |=> free_mask[$past(ret_phys)]);  // R7
    AST_RECOVER_STALL: assert property (@(posedge clk) disable iff (rst)
        recover |-> !ren_ready);  // R9

    for (genvar g = 0; g < ARCH_REGS; g++) begin : g_mapped
        AST_MAPPED_NOT_FREE: assert property (@(posedge clk) disable iff (rst)
            !free_mask[map_flat[g]]);  // R10
    end
endmodule

bind reg_rename reg_rename_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .ren_valid    (ren_valid),
    .ren_ready    (ren_ready),
    .ren_has_dst  (ren_has_dst),
    .out_dst_phys (out_dst_phys),
    .out_old_phys (out_old_phys),
    .ret_valid    (ret_valid),
    .ret_phys     (ret_phys),
    .recover      (recover),
    .free_mask    (free_mask),
    .map_flat     (map_flat)
);

// File: tb/reg_rename_tb.sv
`timescale 1ns/1ps
module reg_rename_tb;
    import rn_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ren_valid = 1'b0, ren_has_dst = 1'b0, ren_ckpt = 1'b0;
    logic [AW-1:0] ren_dst = '0, ren_src1 = '0, ren_src2 = '0;
    logic ren_ready;
    logic [PW-1:0] out_src1_phys, out_src2_phys, out_dst_phys, out_old_phys;
    logic ret_valid = 1'b0, recover = 1'b0;
    logic [PW-1:0] ret_phys = '0;

    always #5 clk = ~clk;

    reg_rename u_dut (.*);

    int n_chk = 0;
    int n_fail = 0;
    int m_map [ARCH_REGS];
    int m_ckpt[ARCH_REGS];
    bit m_free [PHYS_REGS];
    bit m_since[PHYS_REGS];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int m_lowest();
        for (int i = 0; i < PHYS_REGS; i++) if (m_free[i]) return i;
        return -1;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < ARCH_REGS; i++) begin m_map[i] = i; m_ckpt[i] = i; end
        for (int i = 0; i < PHYS_REGS; i++) begin m_free[i] = (i >= ARCH_REGS); m_since[i] = 0; end
    endtask

    // one rename request; checks all outputs against the model
    task automatic do_rename(input bit hd, input int d, input int s1, input int s2, input bit ck);
        int exp_dst;
        @(negedge clk);
        ren_valid = 1'b1; ren_has_dst = hd; ren_ckpt = ck;
        ren_dst = AW'(d); ren_src1 = AW'(s1); ren_src2 = AW'(s2);
        #1;
        exp_dst = m_lowest();
        chk(ren_ready === (exp_dst >= 0), "R6 ready", int'(ren_ready), int'(exp_dst >= 0));
        chk(out_src1_phys === PW'(m_map[s1]), "R2 src1", int'(out_src1_phys), m_map[s1]);
        chk(out_src2_phys === PW'(m_map[s2]), "R2 src2", int'(out_src2_phys), m_map[s2]);
        if (hd && exp_dst >= 0) begin
            chk(out_dst_phys === PW'(exp_dst), "R3 dst alloc", int'(out_dst_phys), exp_dst);
            chk(out_old_phys === PW'(m_map[d]), "R4 old mapping", int'(out_old_phys), m_map[d]);
        end
        @(posedge clk);
        if (exp_dst >= 0) begin
            if (hd) begin
                m_free[exp_dst] = 0; m_since[exp_dst] = 1; m_map[d] = exp_dst;
            end
            if (ck) begin
                m_ckpt = m_map;
                for (int i = 0; i < PHYS_REGS; i++) m_since[i] = 0;
            end
        end
        #1 ren_valid = 1'b0; ren_ckpt = 1'b0;
    endtask

    task automatic do_retire(input int tag);
        @(negedge clk);
        ret_valid = 1'b1; ret_phys = PW'(tag);
        @(posedge clk);
        m_free[tag] = 1;
        #1 ret_valid = 1'b0;
    endtask

    task automatic do_recover();
        @(negedge clk);
        recover = 1'b1; ren_valid = 1'b1; ren_has_dst = 1'b1;
        #1 chk(ren_ready === 1'b0, "R9 ready during recover", int'(ren_ready), 0);
        @(posedge clk);
        m_map = m_ckpt;
        for (int i = 0; i < PHYS_REGS; i++) begin
            if (m_since[i]) m_free[i] = 1;
            m_since[i] = 0;
        end
        #1 recover = 1'b0; ren_valid = 1'b0;
    endtask

    // lookups of every arch register without allocating
    task automatic check_all_maps(input string req);
        for (int i = 0; i < ARCH_REGS; i += 2) begin
            @(negedge clk);
            ren_valid = 1'b0; ren_src1 = AW'(i); ren_src2 = AW'(i + 1);
            #1;
            chk(out_src1_phys === PW'(m_map[i]), req, int'(out_src1_phys), m_map[i]);
            chk(out_src2_phys === PW'(m_map[i + 1]), req, int'(out_src2_phys), m_map[i + 1]);
        end
    endtask

    task automatic t_reset();
        do_reset();
        #1 chk(ren_ready === 1'b1, "R1 ready after reset", int'(ren_ready), 1);
        check_all_maps("R1 reset mapping");
        do_rename(1, 0, 0, 0, 0);  // R1: first pool entry is 8
    endtask

    task automatic t_basic();
        do_reset();
        do_rename(1, 3, 3, 1, 0);  // R2: src equals dst sees old, R3 gets 8
        do_rename(1, 5, 3, 5, 0);  // R3: r3 now reads 8
        do_rename(1, 3, 3, 3, 0);  // R4: old of r3 is 8
        check_all_maps("R3 table update");
    endtask

    task automatic t_nodst();
        do_reset();
        do_rename(0, 2, 2, 4, 0);  // R5: no allocation
        check_all_maps("R5 table unchanged");
        do_rename(1, 2, 2, 2, 0);  // R5: still receives 8
    endtask

    task automatic t_exhaust();
        do_reset();
        for (int k = 0; k < PHYS_REGS - ARCH_REGS; k++) do_rename(1, 0, 0, 1, 0);
        // R6: pool empty, request is refused; R7: displaced tags 8..14 stay reserved
        do_rename(1, 4, 0, 4, 0);
        check_all_maps("R6 no update while stalled");
        do_retire(0);
        do_rename(1, 4, 4, 0, 0);  // R7: retired tag 0 is handed out next
        do_rename(1, 6, 6, 6, 0);  // R6: empty again
    endtask

    task automatic t_recover();
        do_reset();
        do_rename(1, 1, 0, 0, 0);  // p8, old 1
        do_rename(1, 2, 1, 0, 1);  // p9 with checkpoint
        do_rename(1, 1, 1, 2, 0);  // p10, squashed later
        do_rename(1, 3, 3, 1, 0);  // p11, squashed later
        do_retire(1);              // older instruction retires old tag 1
        do_recover();
        check_all_maps("R8 restored mapping");
        do_rename(1, 5, 1, 3, 0);  // R8: tag 1 kept free, lowest
        do_rename(1, 6, 2, 5, 0);  // R8: squashed tag 10 back in pool
        do_rename(1, 7, 7, 6, 0);  // R8: then 11
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_nodst();
        t_exhaust();
        t_recover();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule